// File: doc/BRIEF.md
# Cell Integrity Check Interrupt Unit

This unit sits on the transmit cell path of an ATM user-network interface, beside the point where 53-octet cells leave the transmit FIFO. It follows the cell boundaries with a start-of-cell strobe and a per-octet valid signal. Only the fifth octet of each cell is compared with an expected integrity pattern. A mismatch sets a sticky status flag. When the interrupt is enabled, the status flag drives the unit's bit of the chip-level interrupt summary.

The unit holds one 8-bit control register on the microprocessor bus at offset 0x60. Reading that register clears the status flag, and the summary bit drops with it. The remaining control bits are plain storage, and their values are exported to the neighbouring transmit functions: scrambling, coset, header error control insertion, generic flow control insertion and idle-cell header error control.

Top module: `cell_chk_irq`

## Requirements
- R1: Only the octet in the fifth position of a cell is compared with the expected pattern. A value other than the pattern in any other octet position causes no error.
- R2: A fifth-octet mismatch sets status bit 0 of the control register (offset 0x60) at the next clock edge. The bit then stays set until a read clears it.
- R3: Control bit 2 is the interrupt enable. irq_o equals status AND enable, so it is 0 whenever bit 2 is 0.
- R4: A read at offset 0x60 returns the register value as it was before the read, then clears bit 0 and irq_o at the next edge. A read at any other offset clears nothing.
- R5: Bits 7..1 are read/write. A written value of bit 0 is ignored. Writes to other offsets change nothing. The exported enables are: bit 7 scr_en_o, bit 6 coset_en_o, bit 5 hec_ins_en_o, bit 3 gfc_ins_en_o, bit 1 idle_hec_en_o.
- R6: Control bit 4 selects the expected pattern: 0 selects 0x55 and 1 selects 0xAA.
- R7: Octet counting works as follows:
  - Octet 1 is a valid cycle with sof_i high.
  - Cycles with oct_vld_i low are not counted, and sof_i in such a cycle is ignored.
  - A new start-of-cell restarts the count at 1.
  - Octets after the 53rd that arrive without a new start-of-cell are not checked.
- R8: If a mismatch and a read at 0x60 fall in the same cycle, bit 0 remains set afterwards.
- R9: After reset, the control register reads 0x00 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| oct_vld_i | input | 1 | Cell octet valid |
| sof_i | input | 1 | Start of cell, qualified by oct_vld_i |
| oct_i | input | 8 | Cell octet |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data: the control register at 0x60, 0 at any other offset |
| irq_o | output | 1 | Interrupt summary bit from this unit |
| scr_en_o | output | 1 | Scrambler enable |
| coset_en_o | output | 1 | Coset enable |
| hec_ins_en_o | output | 1 | Header error control insertion enable |
| gfc_ins_en_o | output | 1 | Generic flow control insertion enable |
| idle_hec_en_o | output | 1 | Idle-cell header error control enable |

## Verification
The bench builds the unit with its default parameters: 53-octet cells, a check at position 5, offset 0x60 and patterns 0x55/0xAA. With these values, a full cell is short enough to send many times with idle gaps, resynchronisations and overruns past octet 53. A read can also be placed exactly on the fifth octet to exercise the collision between a read and an error. Both pattern selections are tested with both matching and mismatching fifth octets, and the enable is exercised at both values.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned B_STAT  = 0;
  localparam int unsigned B_IHEC  = 1;
  localparam int unsigned B_IEN   = 2;
  localparam int unsigned B_GFC   = 3;
  localparam int unsigned B_PSEL  = 4;
  localparam int unsigned B_HEC   = 5;
  localparam int unsigned B_COSET = 6;
  localparam int unsigned B_SCR   = 7;
endpackage

// File: rtl/ccu_octet_ctr.sv
module ccu_octet_ctr #(
  parameter int unsigned CELL_LEN = 53,
  parameter int unsigned CHK_POS  = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic sof_i,
  output logic chk_o
);
  localparam int unsigned CW = $clog2(CELL_LEN + 1);
  localparam logic [CW-1:0] LEN_C = CW'(CELL_LEN);
  localparam logic [CW-1:0] POS_C = CW'(CHK_POS);

  logic [CW-1:0] cnt_q, pos;

  // cnt_q == 0 means outside any cell
  always_comb begin
    if (sof_i) pos = CW'(1);
    else if (cnt_q != '0 && cnt_q < LEN_C) pos = cnt_q + CW'(1);
    else pos = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (vld_i) cnt_q <= pos;
  end

  assign chk_o = vld_i && (pos == POS_C);

  // R7
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LEN_C);
  // R1
  single_chk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_o |=> !chk_o);
endmodule

// File: rtl/ccu_pat_cmp.sv
module ccu_pat_cmp #(
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] PAT0 = 8'h55,
  parameter logic [DW-1:0] PAT1 = 8'hAA
) (
  input  logic          chk_i,
  input  logic          sel_i,
  input  logic [DW-1:0] data_i,
  output logic          err_o
);
  logic [DW-1:0] exp_pat;
  assign exp_pat = sel_i ? PAT1 : PAT0;
  assign err_o   = chk_i && (data_i != exp_pat);
endmodule

// File: rtl/ccu_ctrl_reg.sv
module ccu_ctrl_reg
  import ccu_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          err_i,
  output logic [DW-1:0] ctrl_o
);
  logic [DW-1:1] rw_q;
  logic          stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rw_q   <= '0;
      stat_q <= 1'b0;
    end else begin
      if (wr_i) rw_q <= wdata_i[DW-1:1];
      // error wins over clear-on-read
      if (err_i) stat_q <= 1'b1;
      else if (rd_i) stat_q <= 1'b0;
    end
  end

  assign ctrl_o = {rw_q, stat_q};

  // R2
  stat_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> ctrl_o[B_STAT]);
  // R2
  stat_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[B_STAT]) |-> $past(err_i));
  // R4
  rd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !err_i) |=> !ctrl_o[B_STAT]);
  // R5
  rw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ctrl_o[DW-1:1]));
endmodule

// File: rtl/cell_chk_irq.sv
module cell_chk_irq
  import ccu_pkg::*;
#(
  parameter int unsigned   CELL_LEN  = 53,
  parameter int unsigned   CHK_POS   = 5,
  parameter int unsigned   AW        = 8,
  parameter logic [AW-1:0] CTRL_ADDR = 8'h60,
  parameter logic [7:0]    PAT0      = 8'h55,
  parameter logic [7:0]    PAT1      = 8'hAA
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          oct_vld_i,
  input  logic          sof_i,
  input  logic [DW-1:0] oct_i,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o,
  output logic          scr_en_o,
  output logic          coset_en_o,
  output logic          hec_ins_en_o,
  output logic          gfc_ins_en_o,
  output logic          idle_hec_en_o
);
  logic          chk, err, hit, wr_hit, rd_hit;
  logic [DW-1:0] ctrl;

  assign hit    = (bus_addr_i == CTRL_ADDR);
  assign wr_hit = bus_wr_i && hit;
  assign rd_hit = bus_rd_i && hit;

  ccu_octet_ctr #(.CELL_LEN(CELL_LEN), .CHK_POS(CHK_POS)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(oct_vld_i),
    .sof_i(sof_i), .chk_o(chk)
  );

  ccu_pat_cmp #(.DW(DW), .PAT0(PAT0), .PAT1(PAT1)) u_cmp (
    .chk_i(chk), .sel_i(ctrl[B_PSEL]), .data_i(oct_i), .err_o(err)
  );

  ccu_ctrl_reg u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_hit), .rd_i(rd_hit),
    .wdata_i(bus_wdata_i), .err_i(err), .ctrl_o(ctrl)
  );

  assign bus_rdata_o   = hit ? ctrl : '0;
  assign irq_o         = ctrl[B_STAT] & ctrl[B_IEN];
  assign scr_en_o      = ctrl[B_SCR];
  assign coset_en_o    = ctrl[B_COSET];
  assign hec_ins_en_o  = ctrl[B_HEC];
  assign gfc_ins_en_o  = ctrl[B_GFC];
  assign idle_hec_en_o = ctrl[B_IHEC];

  // R3
  irq_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err && ctrl[B_IEN] && !wr_hit) |=> irq_o);
  // R4
  irq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && !err) |=> !irq_o);
  // R8
  keep_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && err) |=> ctrl[B_STAT]);
endmodule

// File: tb/cell_chk_irq_tb_top.sv
`timescale 1ns/1ps
module cell_chk_irq_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       vld = 1'b0, sof = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] oct = '0, addr = '0, wdata = '0, rdata;
  logic       irq, scr, cos, hec, gfc, ihec;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:1] m_ctrl = '0;
  logic       m_stat = 1'b0;

  always #5 clk = ~clk;

  cell_chk_irq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .oct_vld_i(vld), .sof_i(sof), .oct_i(oct),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .scr_en_o(scr), .coset_en_o(cos),
    .hec_ins_en_o(hec), .gfc_ins_en_o(gfc), .idle_hec_en_o(ihec)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // monitor: compares every read at 0x60 with the scoreboard queue
  initial forever begin
    @(negedge clk); #2;
    if (rd && addr == 8'h60) begin
      logic [7:0] e;
      if (exp_q.size() == 0) check(1'b0, "R4 unexpected read", rdata, 8'h00);
      else begin
        e = exp_q.pop_front();
        check(rdata == e, "R2/R4/R5 ctrl read", rdata, e);
      end
    end
  end

  function automatic logic [7:0] pat();
    return m_ctrl[4] ? 8'hAA : 8'h55;
  endfunction

  task automatic rd_ctrl();
    @(negedge clk);
    rd = 1'b1; addr = 8'h60;
    exp_q.push_back({m_ctrl, m_stat});
    m_stat = 1'b0;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    if (a == 8'h60) m_ctrl = d[7:1];
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic put(input bit s, input logic [7:0] d);
    @(negedge clk);
    vld = 1'b1; sof = s; oct = d;
  endtask

  task automatic idle();
    @(negedge clk);
    vld = 1'b0; sof = 1'b0;
  endtask

  // sends a cell; octets other than the fifth carry fill; gaps insert invalid cycles with sof high
  task automatic send_cell(input logic [7:0] fifth, input logic [7:0] fill, input bit gaps);
    for (int i = 1; i <= 53; i++) begin
      if (gaps && (i % 7 == 0)) begin
        @(negedge clk); vld = 1'b0; sof = 1'b1;
      end
      put(i == 1, (i == 5) ? fifth : fill);
    end
    idle();
    if (fifth != pat()) m_stat = 1'b1;
  endtask

  task automatic chk_irq(input string req);
    @(negedge clk); #2;
    check(irq == (m_stat & m_ctrl[2]), req, {7'd0, irq}, {7'd0, m_stat & m_ctrl[2]});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      check(1'b0, "watchdog", 8'h00, 8'h01);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    chk_irq("R9 irq after reset");
    rd_ctrl();
    // R5 read/write bits, bit 0 not writable, exports
    wr_reg(8'h60, 8'hFF);
    @(negedge clk); #2;
    check({scr, cos, hec, gfc, ihec} == 5'b11111, "R5 exports", {3'd0, scr, cos, hec, gfc, ihec}, 8'h1F);
    rd_ctrl();
    wr_reg(8'h60, 8'hA2);
    @(negedge clk); #2;
    check({scr, cos, hec, gfc, ihec} == 5'b10101, "R5 exports", {3'd0, scr, cos, hec, gfc, ihec}, 8'h15);
    wr_reg(8'h61, 8'h5D); // other offset ignored
    rd_ctrl();
    // R1/R6 good cell, pattern 0x55, other octets mismatch
    wr_reg(8'h60, 8'h04);
    send_cell(8'h55, 8'h00, 1'b0);
    chk_irq("R1 no error on matching fifth");
    rd_ctrl();
    // R2/R3 error with enable
    send_cell(8'h54, 8'h55, 1'b1);
    chk_irq("R3 irq with enable");
    // R4 read elsewhere clears nothing
    @(negedge clk); rd = 1'b1; addr = 8'h05;
    @(negedge clk); rd = 1'b0; #2;
    check(irq == 1'b1, "R4 other offset keeps irq", {7'd0, irq}, 8'h01);
    rd_ctrl();
    chk_irq("R4 irq cleared by read");
    rd_ctrl();
    // R6 pattern 0xAA
    wr_reg(8'h60, 8'h14);
    send_cell(8'hAA, 8'h55, 1'b0);
    chk_irq("R6 0xAA accepted");
    send_cell(8'h55, 8'hAA, 1'b0);
    chk_irq("R6 0x55 rejected under sel 1");
    rd_ctrl();
    // R3 disabled enable
    wr_reg(8'h60, 8'h00);
    send_cell(8'h01, 8'h55, 1'b0);
    chk_irq("R3 irq masked");
    rd_ctrl();
    // R7 resync: new sof after three octets; old fifth position carries 0x33
    put(1'b1, 8'h55); put(1'b0, 8'h55); put(1'b0, 8'h55);
    put(1'b1, 8'h55); put(1'b0, 8'h33); put(1'b0, 8'h55); put(1'b0, 8'h55);
    put(1'b0, 8'h55); put(1'b0, 8'h00);
    idle();
    rd_ctrl(); // R7 expected no error
    // R7 octets past 53 without sof unchecked
    send_cell(8'h55, 8'h55, 1'b0);
    for (int i = 0; i < 12; i++) put(1'b0, 8'h00);
    idle();
    rd_ctrl();
    // R8 read on the fifth octet's cycle
    wr_reg(8'h60, 8'h04);
    put(1'b1, 8'h55); put(1'b0, 8'h55); put(1'b0, 8'h55); put(1'b0, 8'h55);
    put(1'b0, 8'h00);
    rd = 1'b1; addr = 8'h60;
    exp_q.push_back({m_ctrl, 1'b0});
    @(negedge clk); rd = 1'b0; vld = 1'b0;
    m_stat = 1'b1;
    chk_irq("R8 flag kept on collision");
    rd_ctrl();
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4 pending reads", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule